// File: doc/BRIEF.md
# USB Host Controller Register Block

This block holds the software-visible registers of a two-port full/low-speed USB host controller. It sits on a small I/O bus that has an address, a write strobe, a read strobe and an access size. The registers cover command, status, interrupt enable, frame number, frame-list base, start-of-frame timing and one control register per root port. Reads return data one cycle after the read strobe. The block drives a level interrupt. The schedule walker and packet engine live elsewhere. They report into this block through a per-frame completion mask and three fault flags.

A 1 ms frame tick advances the 11-bit frame counter while the controller runs. On the same tick, the completion causes gathered during the previous frame are turned into a transfer interrupt. Per-port attach, detach and low-speed inputs update the port registers. Per-port reset requests leave the block as one-cycle pulses.

Top module: `usbhc_regs`

## Requirements
- R1: After rst_n the block reads: command 0, status 0, interrupt enable 0, frame-list base 0, frame number 0, SOF timing 0x40, every port register 0x0080. irq and port_reset are low.
- R2: bus_size 0 is 8-bit, 1 is 16-bit, and 2 or 3 is 32-bit. The 16-bit offsets are command 0x00, status 0x02, enable 0x04, frame 0x06, and port n at 0x10+2n. The 32-bit offset is frame-list base 0x08. The 8-bit offset is SOF timing 0x0C. Any other 16-bit offset reads 0xFF7F, any other 32-bit offset 0xFFFFFFFF, and any other 8-bit offset 0xFF. bus_rdata carries the value of the cycle in which bus_rd was high, starting one cycle later.
- R3: Status bit5 is halted. A command write whose bit0 rises from 0 to 1 clears it. A command write with bit0 at 0 sets it. A tick while bit0 of the command is 0 also sets it.
- R4: Writing ones to status clears those bits and never sets any. Writing status bit0 also clears both hidden cause flags.
- R5: irq is high when any of these holds: complete flag with enable bit2; short flag with enable bit3; status bit1 with enable bit0; status bit2 with enable bit1; status bit3; status bit4. sched_flag bits 0, 1 and 2 set status bits 1, 3 and 4. irq follows the register state one cycle after the update.
- R6: The frame number takes the low 11 bits of a write only while halted is set. Otherwise the write is ignored.
- R7: On a tick while running, pend_mask bit0 sets the complete flag and bit1 sets the short flag. A nonzero mask sets status bit0. The frame number then increments modulo 2048.
- R8: A write to the frame-list base stores bits 31:12 and reads the low 12 bits as 0. A byte write at 0x0C sets SOF timing.
- R9: A port write takes bit2 and bits 15:9 from the data. It clears bit1 and bit3 where the data has a one. It leaves bits 0 and 4 to 8 unchanged.
- R10: port_reset[n] pulses for one cycle, in the cycle after a port-n write, only if that write raises bit9 from 0 to 1 while a device is attached on port n.
- R11: Attach sets port bits 0 and 1 and copies dev_lowspeed to bit8. Detach clears bit0 and sets bit1 if bit0 was set, and clears bit2 and sets bit3 if bit2 was set. Attach wins over a detach in the same cycle.
- R12: An attach or detach while command bit3 is set sets command bit4 and status bit2.
- R13: A command write with bit2 set pulses port_reset on every attached port. It then performs the same reset as a write with bit1 set: the R1 values except the frame number, with each attached port showing 0x0083 plus its low-speed bit in bit8.
- R14: Within one cycle the bus write applies first, then the tick, then the fault and port inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2/3 long |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| frame_tick | input | 1 | 1 ms frame tick |
| pend_mask | input | 2 | Causes from last frame: bit0 complete, bit1 short packet |
| sched_flag | input | 3 | Set status: bit0 error, bit1 host system error, bit2 process error |
| dev_attach | input | NPORTS | Per-port attach pulse |
| dev_detach | input | NPORTS | Per-port detach pulse |
| dev_lowspeed | input | NPORTS | Low-speed indication sampled on attach |
| port_reset | output | NPORTS | Per-port reset pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: two ports and an 11-bit frame number. With these values the 0x14 offset lies just past the last port and has to read as unused. Loading 0x7FF while halted lets a single tick show the wrap to zero. A random phase then drives overlapping writes, ticks, faults and port events in the same cycle. This reaches the R14 ordering and the resume path under global suspend far more often than directed steps would.

// File: rtl/usbhc_regs.sv
module usbhc_regs #(
  parameter int NPORTS = 2,
  parameter int FN_BITS = 11,
  parameter logic [7:0] SOF_INIT = 8'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_size,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frame_tick,
  input  logic [1:0]        pend_mask,
  input  logic [2:0]        sched_flag,
  input  logic [NPORTS-1:0] dev_attach,
  input  logic [NPORTS-1:0] dev_detach,
  input  logic [NPORTS-1:0] dev_lowspeed,
  output logic [NPORTS-1:0] port_reset,
  output logic              irq
);
  localparam logic [15:0] PORT_INIT = 16'h0080;
  localparam logic [15:0] PORT_KEEP = 16'h01FB;
  localparam logic [15:0] PORT_W1C  = 16'h000A;
  localparam logic [4:0]  PORT_BASE = 5'h10;

  logic [15:0] cmd_q, cmd_n, intr_q, intr_n;
  logic [5:0]  sts_q, sts_n;
  logic [1:0]  hid_q, hid_n;
  logic [FN_BITS-1:0] frn_q, frn_n;
  logic [19:0] flb_q, flb_n;
  logic [7:0]  sof_q, sof_n;
  logic [NPORTS-1:0][15:0] prt_q, prt_n;
  logic [NPORTS-1:0] present_q, present_n, ls_q, ls_n, prst_q, prst_n;
  logic [31:0] rd_val;
  logic [15:0] wv, word_rd;
  logic wr_b, wr_w, wr_l, ctl_reset, wake;

  assign wv   = bus_wdata[15:0];
  assign wr_b = bus_wr && bus_size == 2'd0;
  assign wr_w = bus_wr && bus_size == 2'd1;
  assign wr_l = bus_wr && bus_size[1];

  always_comb begin
    cmd_n = cmd_q; sts_n = sts_q; intr_n = intr_q; hid_n = hid_q;
    frn_n = frn_q; flb_n = flb_q; sof_n = sof_q; prt_n = prt_q;
    present_n = present_q; ls_n = ls_q; prst_n = '0;
    ctl_reset = 1'b0; wake = 1'b0;

    if (wr_w) begin
      case (bus_addr)
        5'h00: begin
          if (wv[2]) begin
            prst_n = present_q;
            ctl_reset = 1'b1;
          end else if (wv[1]) begin
            ctl_reset = 1'b1;
          end else begin
            if (wv[0] && !cmd_q[0]) sts_n[5] = 1'b0;
            else if (!wv[0]) sts_n[5] = 1'b1;
            cmd_n = wv;
          end
        end
        5'h02: begin
          sts_n = sts_q & ~wv[5:0];
          if (wv[0]) hid_n = 2'b00;
        end
        5'h04: intr_n = wv;
        5'h06: if (sts_q[5]) frn_n = bus_wdata[FN_BITS-1:0];
        default: ;
      endcase
      for (int i = 0; i < NPORTS; i++) begin
        if (bus_addr == PORT_BASE + 5'(2 * i)) begin
          if (present_q[i] && wv[9] && !prt_q[i][9]) prst_n[i] = 1'b1;
          prt_n[i] = ((prt_q[i] & PORT_KEEP) | (wv & ~PORT_KEEP)) & ~(wv & PORT_W1C);
        end
      end
    end
    if (wr_l && bus_addr == 5'h08) flb_n = bus_wdata[31:12];
    if (wr_b && bus_addr == 5'h0C) sof_n = bus_wdata[7:0];

    if (ctl_reset) begin
      cmd_n = '0; sts_n = '0; hid_n = '0; intr_n = '0; flb_n = '0; sof_n = SOF_INIT;
      for (int i = 0; i < NPORTS; i++)
        prt_n[i] = present_q[i] ? (PORT_INIT | 16'h0003 | {7'd0, ls_q[i], 8'd0}) : PORT_INIT;
    end

    if (frame_tick) begin
      if (!cmd_n[0]) begin
        sts_n[5] = 1'b1;
      end else begin
        if (pend_mask != 2'b00) begin
          hid_n = hid_n | pend_mask;
          sts_n[0] = 1'b1;
        end
        frn_n = frn_n + 1'b1;
      end
    end

    sts_n[1] = sts_n[1] | sched_flag[0];
    sts_n[3] = sts_n[3] | sched_flag[1];
    sts_n[4] = sts_n[4] | sched_flag[2];

    for (int i = 0; i < NPORTS; i++) begin
      if (dev_attach[i]) begin
        prt_n[i][1:0] = 2'b11;
        prt_n[i][8] = dev_lowspeed[i];
        present_n[i] = 1'b1;
        ls_n[i] = dev_lowspeed[i];
        wake = 1'b1;
      end else if (dev_detach[i]) begin
        if (prt_n[i][0]) prt_n[i][1:0] = 2'b10;
        if (prt_n[i][2]) begin
          prt_n[i][2] = 1'b0;
          prt_n[i][3] = 1'b1;
        end
        present_n[i] = 1'b0;
        wake = 1'b1;
      end
    end
    if (wake && cmd_n[3]) begin
      cmd_n[4] = 1'b1;
      sts_n[2] = 1'b1;
    end
  end

  always_comb begin
    word_rd = 16'hFF7F;
    case (bus_addr)
      5'h00: word_rd = cmd_q;
      5'h02: word_rd = {10'd0, sts_q};
      5'h04: word_rd = intr_q;
      5'h06: word_rd = 16'(frn_q);
      default: ;
    endcase
    for (int i = 0; i < NPORTS; i++)
      if (bus_addr == PORT_BASE + 5'(2 * i)) word_rd = prt_q[i];
    case (bus_size)
      2'd0:    rd_val = {24'd0, (bus_addr == 5'h0C) ? sof_q : 8'hFF};
      2'd1:    rd_val = {16'd0, word_rd};
      default: rd_val = (bus_addr == 5'h08) ? {flb_q, 12'd0} : 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; sts_q <= '0; intr_q <= '0; hid_q <= '0; frn_q <= '0;
      flb_q <= '0; sof_q <= SOF_INIT; present_q <= '0; ls_q <= '0;
      prst_q <= '0; bus_rdata <= '0;
      for (int i = 0; i < NPORTS; i++) prt_q[i] <= PORT_INIT;
    end else begin
      cmd_q <= cmd_n; sts_q <= sts_n; intr_q <= intr_n; hid_q <= hid_n;
      frn_q <= frn_n; flb_q <= flb_n; sof_q <= sof_n; prt_q <= prt_n;
      present_q <= present_n; ls_q <= ls_n; prst_q <= prst_n;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end

  assign port_reset = prst_q;
  assign irq = (hid_q[0] & intr_q[2]) | (hid_q[1] & intr_q[3]) |
               (sts_q[1] & intr_q[0]) | (sts_q[2] & intr_q[1]) |
               sts_q[3] | sts_q[4];
endmodule

// File: rtl/usbhc_regs_chk.sv
module usbhc_regs_chk #(
  parameter int NPORTS = 2,
  parameter int FN_BITS = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_size,
  input logic [4:0]        bus_addr,
  input logic [2:0]        wlow,
  input logic              frame_tick,
  input logic [2:0]        sched_flag,
  input logic [NPORTS-1:0] dev_attach,
  input logic [NPORTS-1:0] dev_detach,
  input logic              run,
  input logic [5:0]        sts_q,
  input logic [FN_BITS-1:0] frn_q,
  input logic [NPORTS-1:0] present_q,
  input logic [NPORTS-1:0] port_reset,
  input logic              irq
);
  assert_fault_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[3] || sts_q[4]) |-> irq);

  assert_frame_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size == 2'd1 && bus_addr == 5'h06 && !sts_q[5] && !frame_tick) |=> $stable(frn_q));

  assert_tick_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && run && !bus_wr) |=> frn_q == FN_BITS'($past(frn_q) + 1'b1));

  assert_frame_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !bus_wr) |=> $stable(frn_q));

  assert_status_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size == 2'd1 && bus_addr == 5'h02 && !frame_tick && sched_flag == 3'd0 &&
     dev_attach == '0 && dev_detach == '0) |=> ((sts_q & ~$past(sts_q)) == 6'd0));

  assert_reset_needs_device_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (port_reset & ~$past(present_q)) == '0);

  assert_run_clears_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_size == 2'd1 && bus_addr == 5'h00 && wlow == 3'b001 && !run) |=> !sts_q[5]);
endmodule

bind usbhc_regs usbhc_regs_chk #(.NPORTS(NPORTS), .FN_BITS(FN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_size(bus_size), .bus_addr(bus_addr),
  .wlow(bus_wdata[2:0]), .frame_tick(frame_tick), .sched_flag(sched_flag),
  .dev_attach(dev_attach), .dev_detach(dev_detach), .run(cmd_q[0]), .sts_q(sts_q),
  .frn_q(frn_q), .present_q(present_q), .port_reset(port_reset), .irq(irq)
);

// File: tb/usbhc_regs_bench.sv
module usbhc_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_size = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic frame_tick = 0;
  logic [1:0] pend_mask = 0;
  logic [2:0] sched_flag = 0;
  logic [NP-1:0] dev_attach = 0, dev_detach = 0, dev_lowspeed = 0, port_reset;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbhc_regs u_usbhc_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_tick(frame_tick), .pend_mask(pend_mask), .sched_flag(sched_flag),
    .dev_attach(dev_attach), .dev_detach(dev_detach), .dev_lowspeed(dev_lowspeed),
    .port_reset(port_reset), .irq(irq)
  );

  // behavioural reference model
  int m_cmd, m_sts, m_intr, m_hid, m_frn, m_flb, m_sof, m_prst, m_rdata;
  int m_prt[NP];
  bit m_pres[NP], m_ls[NP];
  bit m_rvalid, m_wake;
  int w, pi;

  function automatic int port_idx(input int a);
    if (a >= 16 && a % 2 == 0 && (a - 16) / 2 < NP) return (a - 16) / 2;
    return -1;
  endfunction

  function automatic int m_read(input int sz, input int a);
    int p;
    if (sz == 0) return (a == 12) ? m_sof : 255;
    if (sz >= 2) return (a == 8) ? m_flb : 32'hFFFF_FFFF;
    p = port_idx(a);
    if (p >= 0) return m_prt[p];
    case (a)
      0: return m_cmd;
      2: return m_sts;
      4: return m_intr;
      6: return m_frn;
      default: return 16'hFF7F;
    endcase
  endfunction

  function automatic bit m_irq();
    return ((m_hid & 1) && (m_intr & 4)) || ((m_hid & 2) && (m_intr & 8)) ||
           ((m_sts & 2) && (m_intr & 1)) || ((m_sts & 4) && (m_intr & 2)) ||
           (m_sts & 8) != 0 || (m_sts & 16) != 0;
  endfunction

  task automatic m_ctl_reset();
    m_cmd = 0; m_sts = 0; m_hid = 0; m_intr = 0; m_flb = 0; m_sof = 64;
    for (int p = 0; p < NP; p++)
      m_prt[p] = m_pres[p] ? (16'h0083 | (m_ls[p] ? 16'h0100 : 0)) : 16'h0080;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_pres[p] = 0; m_ls[p] = 0; end
      m_ctl_reset();
      m_frn = 0; m_prst = 0; m_rvalid = 0; m_rdata = 0;
    end else begin
      m_rvalid = bus_rd;
      if (bus_rd) m_rdata = m_read(bus_size, bus_addr);
      m_prst = 0;
      w = bus_wdata[15:0];
      if (bus_wr && bus_size == 1) begin
        pi = port_idx(bus_addr);
        if (bus_addr == 0) begin
          if (w & 4) begin
            for (int p = 0; p < NP; p++) if (m_pres[p]) m_prst |= (1 << p);
            m_ctl_reset();
          end else if (w & 2) m_ctl_reset();
          else begin
            if ((w & 1) && !(m_cmd & 1)) m_sts &= ~32;
            else if (!(w & 1)) m_sts |= 32;
            m_cmd = w;
          end
        end else if (bus_addr == 2) begin
          m_sts &= ~(w & 63);
          if (w & 1) m_hid = 0;
        end else if (bus_addr == 4) m_intr = w;
        else if (bus_addr == 6) begin
          if (m_sts & 32) m_frn = w % 2048;
        end else if (pi >= 0) begin
          if (m_pres[pi] && (w & 16'h200) && !(m_prt[pi] & 16'h200)) m_prst |= (1 << pi);
          m_prt[pi] = ((m_prt[pi] & 16'h01FB) | (w & 16'hFE04)) & ~(w & 16'h000A);
        end
      end
      if (bus_wr && bus_size >= 2 && bus_addr == 8) m_flb = bus_wdata & 32'hFFFF_F000;
      if (bus_wr && bus_size == 0 && bus_addr == 12) m_sof = bus_wdata[7:0];
      if (frame_tick) begin
        if (!(m_cmd & 1)) m_sts |= 32;
        else begin
          if (pend_mask != 0) begin m_hid |= pend_mask; m_sts |= 1; end
          m_frn = (m_frn + 1) % 2048;
        end
      end
      if (sched_flag[0]) m_sts |= 2;
      if (sched_flag[1]) m_sts |= 8;
      if (sched_flag[2]) m_sts |= 16;
      m_wake = 0;
      for (int p = 0; p < NP; p++) begin
        if (dev_attach[p]) begin
          m_prt[p] = (m_prt[p] | 3) & ~16'h0100;
          if (dev_lowspeed[p]) m_prt[p] |= 16'h0100;
          m_pres[p] = 1; m_ls[p] = dev_lowspeed[p]; m_wake = 1;
        end else if (dev_detach[p]) begin
          if (m_prt[p] & 1) m_prt[p] = (m_prt[p] & ~1) | 2;
          if (m_prt[p] & 4) m_prt[p] = (m_prt[p] & ~4) | 8;
          m_pres[p] = 0; m_wake = 1;
        end
      end
      if (m_wake && (m_cmd & 8)) begin m_cmd |= 16; m_sts |= 4; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 irq vs model", {31'd0, irq}, {31'd0, m_irq()});
      chk("R10 port_reset vs model", {30'd0, port_reset}, 32'(m_prst));
      if (m_rvalid) chk("R2 read vs model", bus_rdata, 32'(m_rdata));
    end
  end

  task automatic wr(input logic [1:0] sz, input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [4:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1; bus_size = sz; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic tick(input logic [1:0] m);
    frame_tick = 1; pend_mask = m;
    @(negedge clk);
    frame_tick = 0; pend_mask = 0;
  endtask

  task automatic attach(input int p, input bit ls);
    dev_attach[p] = 1; dev_lowspeed[p] = ls;
    @(negedge clk);
    dev_attach[p] = 0;
  endtask

  task automatic detach(input int p);
    dev_detach[p] = 1;
    @(negedge clk);
    dev_detach[p] = 0;
  endtask

  task automatic fault(input logic [2:0] f);
    sched_flag = f;
    @(negedge clk);
    sched_flag = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 port_reset", {30'd0, port_reset}, 0);
    rd(1, 5'h00, 32'h0, "R1 command");
    rd(1, 5'h02, 32'h0, "R1 status");
    rd(1, 5'h04, 32'h0, "R1 enable");
    rd(1, 5'h06, 32'h0, "R1 frame");
    rd(2, 5'h08, 32'h0, "R1 base");
    rd(0, 5'h0C, 32'h40, "R1 sof");
    rd(1, 5'h10, 32'h80, "R1 port0");
    rd(1, 5'h12, 32'h80, "R1 port1");
    // R2 unused offsets
    rd(1, 5'h0A, 32'hFF7F, "R2 word unused");
    rd(1, 5'h14, 32'hFF7F, "R2 word past ports");
    rd(2, 5'h00, 32'hFFFF_FFFF, "R2 long unused");
    rd(0, 5'h00, 32'hFF, "R2 byte unused");
    // R8
    wr(2, 5'h08, 32'h1234_5ABC);
    rd(2, 5'h08, 32'h1234_5000, "R8 base low bits");
    wr(0, 5'h0C, 32'h55);
    rd(0, 5'h0C, 32'h55, "R8 sof");
    // R3 / R6
    wr(1, 5'h00, 32'h0);
    rd(1, 5'h02, 32'h20, "R3 halted on stop");
    wr(1, 5'h06, 32'h0FFF);
    rd(1, 5'h06, 32'h7FF, "R6 frame write while halted");
    wr(1, 5'h00, 32'h1);
    rd(1, 5'h02, 32'h0, "R3 run clears halted");
    wr(1, 5'h06, 32'h123);
    rd(1, 5'h06, 32'h7FF, "R6 frame write ignored while running");
    // R7
    tick(2'b00);
    rd(1, 5'h06, 32'h0, "R7 frame wraps");
    rd(1, 5'h02, 32'h0, "R7 zero mask leaves status");
    tick(2'b01);
    rd(1, 5'h02, 32'h1, "R7 complete sets status bit0");
    rd(1, 5'h06, 32'h1, "R7 frame increments");
    chk("R5 no enable no irq", {31'd0, irq}, 0);
    wr(1, 5'h04, 32'h4);
    chk("R5 complete with enable bit2", {31'd0, irq}, 1);
    wr(1, 5'h04, 32'h8);
    chk("R5 complete without its enable", {31'd0, irq}, 0);
    tick(2'b10);
    chk("R5 short with enable bit3", {31'd0, irq}, 1);
    // R4
    wr(1, 5'h02, 32'h1);
    chk("R4 hidden flags cleared", {31'd0, irq}, 0);
    rd(1, 5'h02, 32'h0, "R4 status cleared");
    wr(1, 5'h00, 32'h0);
    tick(2'b11);
    rd(1, 5'h06, 32'h2, "R3 tick while stopped holds frame");
    rd(1, 5'h02, 32'h20, "R3 tick while stopped halted");
    // R11 / R9 / R10
    attach(0, 1);
    rd(1, 5'h10, 32'h0183, "R11 attach low speed");
    wr(1, 5'h10, 32'h0004);
    rd(1, 5'h10, 32'h0187, "R9 enable writable");
    wr(1, 5'h10, 32'h0006);
    rd(1, 5'h10, 32'h0185, "R9 connect change w1c");
    wr(1, 5'h10, 32'h0204);
    chk("R10 reset pulse", {30'd0, port_reset}, 2'b01);
    @(negedge clk);
    chk("R10 pulse one cycle", {30'd0, port_reset}, 0);
    rd(1, 5'h10, 32'h0385, "R9 bit9 writable");
    wr(1, 5'h10, 32'h0204);
    chk("R10 no pulse when bit9 already set", {30'd0, port_reset}, 0);
    wr(1, 5'h12, 32'h0200);
    chk("R10 no pulse without device", {30'd0, port_reset}, 0);
    rd(1, 5'h12, 32'h0280, "R9 port1 write");
    wr(1, 5'h10, 32'h01F0);
    rd(1, 5'h10, 32'h0181, "R9 read-only bits kept");
    wr(1, 5'h10, 32'h0004);
    detach(0);
    rd(1, 5'h10, 32'h018A, "R11 detach");
    // R12
    wr(1, 5'h00, 32'h0008);
    attach(1, 0);
    rd(1, 5'h12, 32'h0283, "R11 attach full speed");
    rd(1, 5'h00, 32'h0018, "R12 force resume");
    rd(1, 5'h02, 32'h24, "R12 resume detect");
    chk("R5 resume without enable", {31'd0, irq}, 0);
    wr(1, 5'h04, 32'h2);
    chk("R5 resume with enable bit1", {31'd0, irq}, 1);
    wr(1, 5'h02, 32'h4);
    chk("R4 clear resume", {31'd0, irq}, 0);
    // R5 faults
    fault(3'b010);
    chk("R5 host error no enable", {31'd0, irq}, 1);
    wr(1, 5'h02, 32'h8);
    chk("R5 host error cleared", {31'd0, irq}, 0);
    fault(3'b001);
    chk("R5 error without enable", {31'd0, irq}, 0);
    wr(1, 5'h04, 32'h1);
    chk("R5 error with enable bit0", {31'd0, irq}, 1);
    wr(1, 5'h02, 32'h2);
    fault(3'b100);
    rd(1, 5'h02, 32'h30, "R5 process error status");
    chk("R5 process error irq", {31'd0, irq}, 1);
    wr(1, 5'h02, 32'h10);
    // R13 global reset
    wr(1, 5'h00, 32'h0004);
    chk("R13 global reset pulses attached", {30'd0, port_reset}, 2'b10);
    rd(1, 5'h00, 32'h0, "R13 command");
    rd(1, 5'h02, 32'h0, "R13 status");
    rd(1, 5'h04, 32'h0, "R13 enable");
    rd(2, 5'h08, 32'h0, "R13 base");
    rd(0, 5'h0C, 32'h40, "R13 sof");
    rd(1, 5'h10, 32'h0080, "R13 port0 empty");
    rd(1, 5'h12, 32'h0083, "R13 port1 reattached");
    rd(1, 5'h06, 32'h2, "R13 frame kept");
    wr(1, 5'h04, 32'hF);
    wr(2, 5'h08, 32'hABCD_E123);
    wr(1, 5'h00, 32'h0002);
    chk("R13 controller reset no pulse", {30'd0, port_reset}, 0);
    rd(1, 5'h04, 32'h0, "R13 enable after controller reset");
    rd(2, 5'h08, 32'h0, "R13 base after controller reset");
    // R14 ordering
    wr(1, 5'h00, 32'h1);
    bus_wr = 1; bus_size = 1; bus_addr = 5'h02; bus_wdata = 32'h1;
    frame_tick = 1; pend_mask = 2'b01;
    @(negedge clk);
    bus_wr = 0; frame_tick = 0; pend_mask = 0;
    rd(1, 5'h02, 32'h1, "R14 tick after status clear");
    rd(1, 5'h06, 32'h3, "R14 frame advanced");

    // random phase checked against the model
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = $urandom % 10;
      bus_wr = ($urandom % 4) == 0;
      bus_rd = ($urandom % 2) == 0;
      bus_size = ($urandom % 4 == 0) ? 2'd0 : (($urandom % 5 == 0) ? 2'd2 : 2'd1);
      case (sel)
        0: bus_addr = 5'h00; 1: bus_addr = 5'h02; 2: bus_addr = 5'h04; 3: bus_addr = 5'h06;
        4: bus_addr = 5'h08; 5: bus_addr = 5'h0C; 6: bus_addr = 5'h10; 7: bus_addr = 5'h12;
        8: bus_addr = 5'h14; default: bus_addr = 5'h0A;
      endcase
      bus_wdata = $urandom;
      if (bus_addr == 5'h00 && $urandom % 16 != 0) bus_wdata[2:1] = 2'b00;
      if (bus_addr == 5'h00 && $urandom % 2 == 0) bus_wdata[0] = 1'b1;
      frame_tick = ($urandom % 8) == 0;
      pend_mask = 2'($urandom);
      sched_flag = ($urandom % 32 == 0) ? 3'($urandom) : 3'd0;
      for (int p = 0; p < NP; p++) begin
        dev_attach[p] = ($urandom % 32) == 0;
        dev_detach[p] = ($urandom % 32) == 0;
        dev_lowspeed[p] = 1'($urandom);
      end
      @(negedge clk);
    end
    bus_wr = 0; bus_rd = 0; frame_tick = 0; sched_flag = 0; dev_attach = 0; dev_detach = 0;
    @(negedge clk);
    finish_run();
  end
endmodule